// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Select

This block sits beside the execute stage of a five-stage, in-order, word-addressed pipeline with eight architectural registers. The register file in this pipeline does not pass a value written during write-back to a decode read in the same cycle. Decode can therefore capture a stale operand even when the producing instruction is already retiring. The block corrects both ALU operands of the instruction held in the ID/EX register before the ALU uses them.

Three younger-to-older producer slots are examined: the EX/MEM register, the MEM/WB register, and a WB/END register that keeps the instruction that retired one cycle earlier. For each slot the block decodes from the opcode whether the instruction writes a register and which one. It then compares that destination with the regA and regB fields of the consumer. Each operand takes the value of the youngest matching producer, or the value captured at decode when no slot matches. The block is purely combinational. It has no clock and holds no state. Stall insertion, the register file and memory are handled elsewhere.

Top module: `fwd_unit`

## Requirements
- R1: Operand A equals the forwarded value of the youngest producer whose destination register equals the consumer's regA field (bits 21..19).
- R2: Operand B is selected the same way using the consumer's regB field (bits 18..16), and independently of operand A.
- R3: When several slots write the matching register, EX/MEM wins over MEM/WB, and MEM/WB wins over WB/END.
- R4: A value forwarded from the EX/MEM slot is that slot's ALU result.
- R5: A value forwarded from MEM/WB or WB/END is that slot's write-back data. The WB/END slot covers a register written during the same cycle as the decode read.
- R6: Opcodes add (0) and nor (1) in bits 24..22 produce the register in bits 2..0.
- R7: Opcode lw (2) produces the register in its regB field (bits 18..16), not the one in bits 2..0.
- R8: Opcodes sw (3), beq (4), halt (6) and noop (7) never forward, whatever their register fields hold. This includes the no-operation word 0x1C00000.
- R9: With no matching producer, each operand equals the value captured from the register file at decode.
- R10: In a single evaluation, the two operands may take their values from two different producer slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_ex_instr | input | 32 | Instruction word of the consumer in ID/EX |
| ex_mem_instr | input | 32 | Instruction word held in EX/MEM |
| mem_wb_instr | input | 32 | Instruction word held in MEM/WB |
| wb_end_instr | input | 32 | Instruction word retired one cycle earlier (WB/END) |
| id_ex_rega_val | input | DATA_W | regA value captured at decode |
| id_ex_regb_val | input | DATA_W | regB value captured at decode |
| ex_mem_alu_result | input | DATA_W | ALU result held in EX/MEM |
| mem_wb_wdata | input | DATA_W | Write-back data held in MEM/WB |
| wb_end_wdata | input | DATA_W | Write-back data held in WB/END |
| opnd_a | output | DATA_W | Selected first ALU operand |
| opnd_b | output | DATA_W | Selected second ALU operand |

## Verification
Priority resolution and independent per-operand selection can both occur in one evaluation. Vectors place a producer of the same register in all three slots, which forces the priority decision. Other vectors point the two source fields at producers in different slots, so the two operands take different sources at once. Each operand is compared against a hand-derived expected source value. The data values given to the slots are all distinct, so a wrong slot or a wrong priority order shows up as a mismatch on the output.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    localparam int INSTR_W   = 32;
    localparam int NUM_REGS  = 8;
    localparam int REG_IDX_W = $clog2(NUM_REGS);
    localparam int OPC_W     = 3;
    localparam int OPC_LSB   = 22;
    localparam int REGA_LSB  = 19;
    localparam int REGB_LSB  = 16;
    localparam int DEST_LSB  = 0;
    localparam int NUM_SRC   = 3;   // producer slots, index 0 youngest
    localparam int SEL_W     = $clog2(NUM_SRC + 1);

    typedef enum logic [OPC_W-1:0] {
        OP_ADD  = 3'd0,
        OP_NOR  = 3'd1,
        OP_LW   = 3'd2,
        OP_SW   = 3'd3,
        OP_BEQ  = 3'd4,
        OP_RSV  = 3'd5,
        OP_HALT = 3'd6,
        OP_NOOP = 3'd7
    } opcode_e;

    typedef logic [REG_IDX_W-1:0] reg_idx_t;

    typedef struct packed {
        opcode_e  opc;
        reg_idx_t ra;
        reg_idx_t rb;
        reg_idx_t rd;
    } fields_t;

    typedef struct packed {
        logic     wr;
        reg_idx_t dst;
    } producer_t;

    // 0 = decode value, then slots in priority order
    typedef enum logic [SEL_W-1:0] {
        SRC_RF    = 2'd0,
        SRC_EXMEM = 2'd1,
        SRC_MEMWB = 2'd2,
        SRC_WBEND = 2'd3
    } src_sel_e;

    function automatic fields_t split_instr(input logic [INSTR_W-1:0] w);
        fields_t f;
        f.opc = opcode_e'(w[OPC_LSB +: OPC_W]);
        f.ra  = w[REGA_LSB +: REG_IDX_W];
        f.rb  = w[REGB_LSB +: REG_IDX_W];
        f.rd  = w[DEST_LSB +: REG_IDX_W];
        return f;
    endfunction

endpackage

// File: rtl/fwd_dest_decode.sv
module fwd_dest_decode
    import fwd_pkg::*;
(
    input  opcode_e   opc,
    input  reg_idx_t  rb,
    input  reg_idx_t  rd,
    output producer_t prod
);

    producer_t prod_d;

    always_comb begin
        prod_d.wr  = 1'b0;
        prod_d.dst = '0;
        unique case (opc)
            OP_ADD, OP_NOR: begin
                prod_d.wr  = 1'b1;
                prod_d.dst = rd;
            end
            OP_LW: begin
                prod_d.wr  = 1'b1;
                prod_d.dst = rb;
            end
            default: begin
                prod_d.wr  = 1'b0;
                prod_d.dst = '0;
            end
        endcase
    end

    assign prod = prod_d;

endmodule

// File: rtl/fwd_src_pick.sv
module fwd_src_pick
    import fwd_pkg::*;
(
    input  reg_idx_t                  src_reg,
    input  producer_t [NUM_SRC-1:0]   prod,
    output src_sel_e                  sel
);

    src_sel_e sel_d;

    // walk oldest to youngest so the youngest match overwrites
    always_comb begin
        sel_d = SRC_RF;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (prod[i].wr && (prod[i].dst == src_reg)) begin
                sel_d = src_sel_e'(SEL_W'(i + 1));
            end
        end
    end

    assign sel = sel_d;

endmodule

// File: rtl/fwd_operand_mux.sv
module fwd_operand_mux
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  src_sel_e          sel,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0] exmem_val,
    input  logic [DATA_W-1:0] memwb_val,
    input  logic [DATA_W-1:0] wbend_val,
    output logic [DATA_W-1:0] opnd
);

    logic [DATA_W-1:0] opnd_d;

    always_comb begin
        unique case (sel)
            SRC_EXMEM: opnd_d = exmem_val;
            SRC_MEMWB: opnd_d = memwb_val;
            SRC_WBEND: opnd_d = wbend_val;
            default:   opnd_d = rf_val;
        endcase
    end

    assign opnd = opnd_d;

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [INSTR_W-1:0] id_ex_instr,
    input  logic [INSTR_W-1:0] ex_mem_instr,
    input  logic [INSTR_W-1:0] mem_wb_instr,
    input  logic [INSTR_W-1:0] wb_end_instr,
    input  logic [DATA_W-1:0]  id_ex_rega_val,
    input  logic [DATA_W-1:0]  id_ex_regb_val,
    input  logic [DATA_W-1:0]  ex_mem_alu_result,
    input  logic [DATA_W-1:0]  mem_wb_wdata,
    input  logic [DATA_W-1:0]  wb_end_wdata,
    output logic [DATA_W-1:0]  opnd_a,
    output logic [DATA_W-1:0]  opnd_b
);

    localparam int NUM_LANE = 2;

    // producer slot words, youngest first
    logic [NUM_SRC-1:0][INSTR_W-1:0] stage_word;
    fields_t   [NUM_SRC-1:0]         stage_f;
    producer_t [NUM_SRC-1:0]         stage_prod;
    logic      [NUM_SRC-1:0]         unused_stage_ra;

    assign stage_word[0] = ex_mem_instr;
    assign stage_word[1] = mem_wb_instr;
    assign stage_word[2] = wb_end_instr;

    generate
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_slot
            assign stage_f[s]         = split_instr(stage_word[s]);
            assign unused_stage_ra[s] = ^stage_f[s].ra;
            fwd_dest_decode u_dec (
                .opc  (stage_f[s].opc),
                .rb   (stage_f[s].rb),
                .rd   (stage_f[s].rd),
                .prod (stage_prod[s])
            );
        end
    endgenerate

    // consumer side
    fields_t id_f;
    logic    unused_id;
    assign id_f      = split_instr(id_ex_instr);
    assign unused_id = ^{id_f.opc, id_f.rd};

    reg_idx_t [NUM_LANE-1:0]              lane_src;
    logic     [NUM_LANE-1:0][DATA_W-1:0]  lane_rf;
    logic     [NUM_LANE-1:0][DATA_W-1:0]  lane_out;
    src_sel_e [NUM_LANE-1:0]              lane_sel;

    assign lane_src[0] = id_f.ra;
    assign lane_src[1] = id_f.rb;
    assign lane_rf[0]  = id_ex_rega_val;
    assign lane_rf[1]  = id_ex_regb_val;

    generate
        for (genvar l = 0; l < NUM_LANE; l++) begin : g_lane
            fwd_src_pick u_pick (
                .src_reg (lane_src[l]),
                .prod    (stage_prod),
                .sel     (lane_sel[l])
            );
            fwd_operand_mux #(.DATA_W(DATA_W)) u_mux (
                .sel       (lane_sel[l]),
                .rf_val    (lane_rf[l]),
                .exmem_val (ex_mem_alu_result),
                .memwb_val (mem_wb_wdata),
                .wbend_val (wb_end_wdata),
                .opnd      (lane_out[l])
            );
        end
    endgenerate

    src_sel_e sel_a;
    src_sel_e sel_b;
    assign sel_a  = lane_sel[0];
    assign sel_b  = lane_sel[1];
    assign opnd_a = lane_out[0];
    assign opnd_b = lane_out[1];

endmodule

// File: rtl/fwd_unit_checker.sv
module fwd_unit_checker
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic [INSTR_W-1:0]       id_ex_instr,
    input logic [INSTR_W-1:0]       ex_mem_instr,
    input logic [INSTR_W-1:0]       mem_wb_instr,
    input logic [INSTR_W-1:0]       wb_end_instr,
    input logic [DATA_W-1:0]        id_ex_rega_val,
    input logic [DATA_W-1:0]        id_ex_regb_val,
    input logic [DATA_W-1:0]        ex_mem_alu_result,
    input logic [DATA_W-1:0]        mem_wb_wdata,
    input logic [DATA_W-1:0]        wb_end_wdata,
    input logic [DATA_W-1:0]        opnd_a,
    input logic [DATA_W-1:0]        opnd_b,
    input producer_t [NUM_SRC-1:0]  stage_prod,
    input src_sel_e                 sel_a,
    input src_sel_e                 sel_b
);

    fields_t c_id, c_ex, c_mw, c_we;
    logic    unused_chk;

    assign c_id = split_instr(id_ex_instr);
    assign c_ex = split_instr(ex_mem_instr);
    assign c_mw = split_instr(mem_wb_instr);
    assign c_we = split_instr(wb_end_instr);
    assign unused_chk = ^{c_id.opc, c_id.rd, c_ex.ra, c_mw.ra, c_we.ra,
                          c_mw.rb, c_mw.rd, c_we.rb, c_we.rd};

    function automatic logic non_producer(input opcode_e o);
        return (o == OP_SW) || (o == OP_BEQ) || (o == OP_HALT) || (o == OP_NOOP);
    endfunction

    always_comb begin
        // R8: store, branch, halt and noop never appear as producers
        p_no_producer_r8: assert (!(non_producer(c_ex.opc) && stage_prod[0].wr) &&
                                  !(non_producer(c_mw.opc) && stage_prod[1].wr) &&
                                  !(non_producer(c_we.opc) && stage_prod[2].wr))
            else $error("non-writing opcode treated as producer");

        // R3: a youngest-slot match must win for operand A
        if (stage_prod[0].wr && stage_prod[0].dst == c_id.ra) begin
            p_exmem_prio_r3: assert (sel_a == SRC_EXMEM)
                else $error("EX/MEM match did not win");
        end

        // R2: operand B follows its own field
        if (stage_prod[0].wr && stage_prod[0].dst == c_id.rb) begin
            p_opb_match_r2: assert (sel_b == SRC_EXMEM)
                else $error("operand B ignored EX/MEM match");
        end

        // R4: EX/MEM selection carries the ALU result
        if (sel_a == SRC_EXMEM) begin
            p_alu_fwd_r4: assert (opnd_a == ex_mem_alu_result)
                else $error("operand A not ALU result");
        end

        // R5: write-back slots carry write-back data
        if (sel_b == SRC_MEMWB) begin
            p_memwb_fwd_r5: assert (opnd_b == mem_wb_wdata)
                else $error("operand B not MEM/WB data");
        end
        if (sel_b == SRC_WBEND) begin
            p_wbend_fwd_r5: assert (opnd_b == wb_end_wdata)
                else $error("operand B not WB/END data");
        end

        // R9: no selection keeps decode values
        if (sel_a == SRC_RF) begin
            p_rf_default_a_r9: assert (opnd_a == id_ex_rega_val)
                else $error("operand A lost decode value");
        end
        if (sel_b == SRC_RF) begin
            p_rf_default_b_r9: assert (opnd_b == id_ex_regb_val)
                else $error("operand B lost decode value");
        end
    end

endmodule

bind fwd_unit fwd_unit_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/fwd_unit_bench.sv
module fwd_unit_bench;

    localparam int DATA_W = 32;
    localparam logic [31:0] NOOP_W = 32'h01C0_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 4 ns period

    logic [31:0] id_ex_instr, ex_mem_instr, mem_wb_instr, wb_end_instr;
    logic [DATA_W-1:0] id_ex_rega_val, id_ex_regb_val;
    logic [DATA_W-1:0] ex_mem_alu_result, mem_wb_wdata, wb_end_wdata;
    logic [DATA_W-1:0] opnd_a, opnd_b;

    fwd_unit #(.DATA_W(DATA_W)) u_fwd_unit (
        .id_ex_instr       (id_ex_instr),
        .ex_mem_instr      (ex_mem_instr),
        .mem_wb_instr      (mem_wb_instr),
        .wb_end_instr      (wb_end_instr),
        .id_ex_rega_val    (id_ex_rega_val),
        .id_ex_regb_val    (id_ex_regb_val),
        .ex_mem_alu_result (ex_mem_alu_result),
        .mem_wb_wdata      (mem_wb_wdata),
        .wb_end_wdata      (wb_end_wdata),
        .opnd_a            (opnd_a),
        .opnd_b            (opnd_b)
    );

    typedef struct {
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        string             req;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    function automatic logic [31:0] mk(input int op, input int ra, input int rb, input int rd);
        logic [31:0] w;
        w = '0;
        w[24:22] = 3'(op);
        w[21:19] = 3'(ra);
        w[18:16] = 3'(rb);
        w[2:0]   = 3'(rd);
        return w;
    endfunction

    task automatic drive(input logic [31:0] id_w, input logic [31:0] ex_w,
                         input logic [31:0] mw_w, input logic [31:0] we_w,
                         input logic [DATA_W-1:0] ea, input logic [DATA_W-1:0] eb,
                         input string req);
        exp_t e;
        @(negedge clk);
        id_ex_instr  = id_w;
        ex_mem_instr = ex_w;
        mem_wb_instr = mw_w;
        wb_end_instr = we_w;
        e.a = ea;
        e.b = eb;
        e.req = req;
        exp_q.push_back(e);
    endtask

    // monitor: compare one item per clock, 1 ns after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (opnd_a !== e.a) begin
                    errors++;
                    $display("FAIL %s operand A actual %h expected %h", e.req, opnd_a, e.a);
                end
                checks++;
                if (opnd_b !== e.b) begin
                    errors++;
                    $display("FAIL %s operand B actual %h expected %h", e.req, opnd_b, e.b);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    localparam logic [31:0] RFA = 32'h0000_0100;
    localparam logic [31:0] RFB = 32'h0000_0200;
    localparam logic [31:0] ALU = 32'h0000_0011;
    localparam logic [31:0] MWD = 32'h0000_0022;
    localparam logic [31:0] WED = 32'h0000_0033;

    initial begin
        id_ex_instr = NOOP_W;
        ex_mem_instr = NOOP_W;
        mem_wb_instr = NOOP_W;
        wb_end_instr = NOOP_W;
        id_ex_rega_val = RFA;
        id_ex_regb_val = RFB;
        ex_mem_alu_result = ALU;
        mem_wb_wdata = MWD;
        wb_end_wdata = WED;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // reset-like state: all slots hold noop -> R9
        drive(mk(0,1,2,3), NOOP_W, NOOP_W, NOOP_W, RFA, RFB, "R9 reset noops");
        // R1 R4 R6: add in EX/MEM writes r1
        drive(mk(0,1,2,3), mk(0,0,0,1), NOOP_W, NOOP_W, ALU, RFB, "R1 R4 R6 add exmem");
        // R2 R6: nor writes r2, only operand B
        drive(mk(0,1,2,3), mk(1,5,5,2), NOOP_W, NOOP_W, RFA, ALU, "R2 R6 nor exmem");
        // R7 R5: lw in MEM/WB writes regB=3, dest field 5 ignored
        drive(mk(0,3,5,0), NOOP_W, mk(2,0,3,5), NOOP_W, MWD, RFB, "R7 R5 lw memwb");
        // R5: WB/END path covers write-back cycle
        drive(mk(0,4,1,0), NOOP_W, NOOP_W, mk(0,0,0,4), WED, RFB, "R5 wbend");
        // R3: all three write r6
        drive(mk(0,6,6,0), mk(0,0,0,6), mk(1,0,0,6), mk(2,0,6,0), ALU, ALU, "R3 all slots");
        // R3: MEM/WB over WB/END
        drive(mk(0,6,6,0), NOOP_W, mk(0,0,0,6), mk(0,0,0,6), MWD, MWD, "R3 memwb over wbend");
        // R8: sw/beq/halt with r1 in every field
        drive(mk(0,1,1,0), mk(3,1,1,1), mk(4,1,1,1), mk(6,1,1,1), RFA, RFB, "R8 sw beq halt");
        // R8: noop word fields are zero; consumer reads r0
        drive(mk(0,0,0,0), NOOP_W, NOOP_W, NOOP_W, RFA, RFB, "R8 noop r0");
        // R8: noop opcode with r2 fields
        drive(mk(0,2,2,0), mk(7,2,2,2), mk(7,2,2,2), mk(7,2,2,2), RFA, RFB, "R8 noop fields");
        // R10: A from EX/MEM, B from WB/END
        drive(mk(0,1,2,0), mk(0,0,0,1), NOOP_W, mk(2,0,2,7), ALU, WED, "R10 split sources");
        // R10: A from WB/END, B from MEM/WB
        drive(mk(0,4,5,0), NOOP_W, mk(1,0,0,5), mk(0,0,0,4), WED, MWD, "R10 split sources 2");
        // R9: producers exist, no register matches
        drive(mk(0,1,2,0), mk(0,0,0,7), mk(2,0,6,1), mk(1,0,0,5), RFA, RFB, "R9 no match");
        // R7: lw dest field matches regA but must not forward
        drive(mk(0,4,2,0), mk(2,0,3,4), NOOP_W, NOOP_W, RFA, RFB, "R7 lw dest field");

        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule